// File: doc/BRIEF.md
# Load Dependence Predictor with Retirement Verification

This block decides, per load instruction, whether the load may run ahead of older stores whose addresses are still unknown. A direct-mapped table, indexed by the low bits of the load's instruction pointer, holds one saturating confidence counter per entry. At dispatch the pipeline presents the load IP and receives a combinational verdict. Upper half of the counter range means "dependent": the load must wait for the older store's address and data so the value can be forwarded. Lower half means "independent": the load may issue speculatively.

When the load retires, the pipeline reports three things: the IP, whether the load actually ran speculatively, and whether an older store really wrote any byte the load read. A speculative load that overlapped an older store is a misprediction. Its entry is forced to strongly dependent, and a one-cycle flush request carrying the offending IP goes out on the next cycle. A retirement without overlap weakens the entry by one step. A flush-pulse machine with states FL_IDLE and FL_PULSE produces the request. FL_IDLE moves to FL_PULSE on a misprediction. FL_PULSE stays in FL_PULSE on another misprediction and otherwise returns to FL_IDLE. Training picks one of ACT_NONE, ACT_SET (misprediction) or ACT_DEC (no overlap).

Top module: `ldep_top`

## Requirements
- R1: After reset every table entry predicts independent (`lk_dep` = 0 for any IP), and `flush_req` is 0.
- R2: `lk_dep` is 1 exactly when the 2-bit counter selected by `lk_ip[5:0]` is 2 or 3. IPs that agree in bits 5:0 share one entry.
- R3: A retirement with `rt_valid`=1, `rt_spec`=1 and `rt_overlap`=1 sets the counter at `rt_ip[5:0]` to 3.
- R4: A retirement with `rt_valid`=1 and `rt_overlap`=0 lowers that counter by one, and the counter saturates at 0.
- R5: A retirement with `rt_valid`=1, `rt_overlap`=1 and `rt_spec`=0 leaves the counter unchanged.
- R6: In the cycle after a misprediction retirement (as in R3), `flush_req` is 1 for exactly one cycle and `flush_ip` equals that retirement's `rt_ip`. In every other cycle `flush_req` is 0 and `flush_ip` is 0.
- R7: If a lookup and a retirement hit the same index in the same cycle, the lookup returns the prediction from before that retirement's update.
- R8: With `rt_valid`=0, the retirement inputs change no counter and raise no flush.
- R9: Mispredictions on consecutive cycles give consecutive flush pulses, each carrying its own IP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_ip | input | 32 | IP of the load being dispatched |
| lk_dep | output | 1 | 1 = wait for older stores, 0 = may issue speculatively |
| rt_valid | input | 1 | A load retires this cycle |
| rt_ip | input | 32 | IP of the retiring load |
| rt_spec | input | 1 | Retiring load executed speculatively |
| rt_overlap | input | 1 | An older store wrote a byte the retiring load read |
| flush_req | output | 1 | One-cycle flush request after a misprediction |
| flush_ip | output | 32 | IP of the mispredicted load while `flush_req` is 1, else 0 |

## Verification
The bench looks up an entry in the same cycle it is being trained. A design that forwarded the new value would report dependence one cycle early. It walks a counter down from 3 through the threshold to 0 and below. An off-by-one in the decrement or a missing saturation would flip the prediction at the wrong step or wrap back to dependent. It also checks that aliasing IPs share an entry, that an overlap on a non-speculative load neither trains nor flushes, and that back-to-back mispredictions each produce their own pulse with their own IP instead of merging into one long pulse.

// File: rtl/ldep_pkg.sv
package ldep_pkg;

    // Flush request generator states
    typedef enum logic [0:0] {
        FL_IDLE  = 1'b0,
        FL_PULSE = 1'b1
    } flush_state_e;

    // Training action chosen at retirement
    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_DEC  = 2'd2
    } train_act_e;

endpackage

// File: rtl/ldep_table.sv
module ldep_table #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [CNT_W-1:0] rd_val_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [CNT_W-1:0] rd_val_b,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_val
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [CNT_W-1:0] cnt_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                cnt_q[g] <= wr_val;
            end
        end
    end

    // Reads see the registered state, so same-cycle writes are not visible
    always_comb begin
        rd_val_a = cnt_q[rd_idx_a];
        rd_val_b = cnt_q[rd_idx_b];
    end
endmodule

// File: rtl/ldep_train.sv
module ldep_train
    import ldep_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             rt_valid,
    input  logic             rt_spec,
    input  logic             rt_overlap,
    input  logic [CNT_W-1:0] cur_cnt,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_val,
    output logic             mispredict
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    train_act_e act;

    always_comb begin
        if (!rt_valid) begin
            act = ACT_NONE;
        end else if (!rt_overlap) begin
            act = ACT_DEC;
        end else if (rt_spec) begin
            act = ACT_SET;
        end else begin
            act = ACT_NONE;
        end
    end

    always_comb begin
        wr_val = cur_cnt;
        unique case (act)
            ACT_SET:  wr_val = CNT_MAX;
            ACT_DEC:  wr_val = (cur_cnt == CNT_MIN) ? CNT_MIN : cur_cnt - 1'b1;
            ACT_NONE: wr_val = cur_cnt;
            default:  wr_val = cur_cnt;
        endcase
        wr_en      = (act != ACT_NONE);
        mispredict = (act == ACT_SET);
    end
endmodule

// File: rtl/ldep_flush_fsm.sv
module ldep_flush_fsm
    import ldep_pkg::*;
#(
    parameter int IP_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mispredict,
    input  logic [IP_W-1:0] bad_ip,
    output logic            flush_req,
    output logic [IP_W-1:0] flush_ip
);
    flush_state_e    state_q, state_d;
    logic [IP_W-1:0] ip_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  state_d = mispredict ? FL_PULSE : FL_IDLE;
            FL_PULSE: state_d = mispredict ? FL_PULSE : FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_IDLE;
            ip_q    <= '0;
        end else begin
            state_q <= state_d;
            if (mispredict) begin
                ip_q <= bad_ip;
            end
        end
    end

    always_comb begin
        flush_req = (state_q == FL_PULSE);
        flush_ip  = flush_req ? ip_q : '0;
    end
endmodule

// File: rtl/ldep_top.sv
module ldep_top #(
    parameter int IP_W  = 32,
    parameter int IDX_W = 6,
    parameter int CNT_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IP_W-1:0] lk_ip,
    output logic            lk_dep,
    input  logic            rt_valid,
    input  logic [IP_W-1:0] rt_ip,
    input  logic            rt_spec,
    input  logic            rt_overlap,
    output logic            flush_req,
    output logic [IP_W-1:0] flush_ip
);
    logic [IDX_W-1:0] lk_idx, rt_idx;
    logic [CNT_W-1:0] lk_cnt, rt_cnt, wr_val;
    logic             wr_en, mispredict;
    logic             unused_hi;

    assign lk_idx    = lk_ip[IDX_W-1:0];
    assign rt_idx    = rt_ip[IDX_W-1:0];
    assign unused_hi = ^{lk_ip[IP_W-1:IDX_W], rt_ip[IP_W-1:IDX_W]};

    ldep_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_a (lk_idx),
        .rd_val_a (lk_cnt),
        .rd_idx_b (rt_idx),
        .rd_val_b (rt_cnt),
        .wr_en    (wr_en),
        .wr_idx   (rt_idx),
        .wr_val   (wr_val)
    );

    ldep_train #(.CNT_W(CNT_W)) u_train (
        .rt_valid   (rt_valid),
        .rt_spec    (rt_spec),
        .rt_overlap (rt_overlap),
        .cur_cnt    (rt_cnt),
        .wr_en      (wr_en),
        .wr_val     (wr_val),
        .mispredict (mispredict)
    );

    ldep_flush_fsm #(.IP_W(IP_W)) u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .mispredict (mispredict),
        .bad_ip     (rt_ip),
        .flush_req  (flush_req),
        .flush_ip   (flush_ip)
    );

    // Upper half of the counter range means "wait for older stores"
    assign lk_dep = lk_cnt[CNT_W-1];
endmodule

// File: rtl/ldep_check.sv
module ldep_check #(
    parameter int IP_W  = 32,
    parameter int IDX_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IP_W-1:0] lk_ip,
    input logic            lk_dep,
    input logic            rt_valid,
    input logic [IP_W-1:0] rt_ip,
    input logic            rt_spec,
    input logic            rt_overlap,
    input logic            flush_req,
    input logic [IP_W-1:0] flush_ip
);
    logic viol;
    assign viol = rt_valid && rt_spec && rt_overlap;

    p_flush_after_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> (flush_req && flush_ip == $past(rt_ip)));

    p_no_spurious_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !viol |=> (!flush_req && flush_ip == '0));

    p_set_dependent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> ((lk_ip[IDX_W-1:0] == $past(rt_ip[IDX_W-1:0])) -> lk_dep));

    p_stay_indep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && !rt_overlap && !lk_dep && lk_ip[IDX_W-1:0] == rt_ip[IDX_W-1:0])
        |=> ((lk_ip == $past(lk_ip)) -> !lk_dep));

    p_hold_nonspec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_valid && rt_overlap && !rt_spec && lk_ip[IDX_W-1:0] == rt_ip[IDX_W-1:0])
        |=> ((lk_ip == $past(lk_ip)) -> (lk_dep == $past(lk_dep))));
endmodule

bind ldep_top ldep_check #(.IP_W(IP_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_ip      (lk_ip),
    .lk_dep     (lk_dep),
    .rt_valid   (rt_valid),
    .rt_ip      (rt_ip),
    .rt_spec    (rt_spec),
    .rt_overlap (rt_overlap),
    .flush_req  (flush_req),
    .flush_ip   (flush_ip)
);

// File: tb/ldep_top_test.sv
module ldep_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int IP_W = 32;
    localparam int ENTRIES = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IP_W-1:0] lk_ip = '0;
    logic            lk_dep;
    logic            rt_valid = 1'b0;
    logic [IP_W-1:0] rt_ip = '0;
    logic            rt_spec = 1'b0;
    logic            rt_overlap = 1'b0;
    logic            flush_req;
    logic [IP_W-1:0] flush_ip;

    int checks = 0;
    int errors = 0;
    int model [ENTRIES];
    logic            exp_flush = 1'b0;
    logic [IP_W-1:0] exp_ip = '0;

    ldep_top uut (
        .clk(clk), .rst_n(rst_n), .lk_ip(lk_ip), .lk_dep(lk_dep),
        .rt_valid(rt_valid), .rt_ip(rt_ip), .rt_spec(rt_spec),
        .rt_overlap(rt_overlap), .flush_req(flush_req), .flush_ip(flush_ip)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL R6 watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic pred(input logic [IP_W-1:0] ip);
        return model[ip[5:0]] >= 2;
    endfunction

    task automatic one_cycle(input logic [IP_W-1:0] lip, input logic rv,
                             input logic [IP_W-1:0] rip, input logic rs,
                             input logic ro, input string tag);
        logic exp_dep;
        @(negedge clk);
        checks++;
        if (flush_req !== exp_flush || flush_ip !== exp_ip) begin
            errors++;
            $display("FAIL %s flush actual=%b/%h expected=%b/%h",
                     tag, flush_req, flush_ip, exp_flush, exp_ip);
        end
        lk_ip = lip; rt_valid = rv; rt_ip = rip; rt_spec = rs; rt_overlap = ro;
        #1;
        exp_dep = pred(lip);
        checks++;
        if (lk_dep !== exp_dep) begin
            errors++;
            $display("FAIL %s lookup ip=%h actual=%b expected=%b", tag, lip, lk_dep, exp_dep);
        end
        exp_flush = 1'b0;
        exp_ip = '0;
        if (rv) begin
            if (rs && ro) begin
                model[rip[5:0]] = 3;
                exp_flush = 1'b1;
                exp_ip = rip;
            end else if (!ro) begin
                if (model[rip[5:0]] > 0) model[rip[5:0]]--;
            end
        end
    endtask

    localparam logic [IP_W-1:0] IP_A = 32'h1000_0005;
    localparam logic [IP_W-1:0] IP_B = 32'h2000_0011;
    localparam logic [IP_W-1:0] IP_C = 32'h3000_0022;
    localparam logic [IP_W-1:0] IP_D = 32'h4000_0033;
    localparam logic [IP_W-1:0] IP_E = 32'h5000_0034;

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < ENTRIES; i++) model[i] = 0;
        #(CLK_PERIOD * 2 + 2);
        // R1: reset state
        checks++;
        if (flush_req !== 1'b0 || lk_dep !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%b/%b expected=0/0", flush_req, lk_dep);
        end
        rst_n = 1'b1;
        one_cycle(32'h0000_0100, 0, 0, 0, 0, "R1");
        one_cycle(IP_C, 0, 0, 0, 0, "R1");
        // R7: violation and lookup of same index in one cycle
        one_cycle(IP_A, 1, IP_A, 1, 1, "R7");
        // R3 / R6: now dependent, flush pulse with IP_A
        one_cycle(IP_A, 0, 0, 0, 0, "R3");
        // R2: alias shares entry; pulse is gone
        one_cycle(IP_A + 32'h40, 0, 0, 0, 0, "R2");
        // R4: walk counter 3 -> 2 -> 1 -> 0 -> 0
        one_cycle(IP_A, 1, IP_A, 0, 0, "R4");
        one_cycle(IP_A, 1, IP_A, 1, 0, "R4");
        one_cycle(IP_A, 1, IP_A, 0, 0, "R4");
        one_cycle(IP_A, 1, IP_A, 0, 0, "R4");
        one_cycle(IP_A, 0, 0, 0, 0, "R4");
        // R5: dependent load that waited does not train or flush
        one_cycle(IP_B, 1, IP_B, 1, 1, "R5");
        one_cycle(IP_B, 1, IP_B, 1, 0, "R5");
        one_cycle(IP_B, 1, IP_B, 0, 1, "R5");
        one_cycle(IP_B, 1, IP_B, 0, 1, "R5");
        // R8: invalid retirement ignored
        one_cycle(IP_C, 0, IP_C, 1, 1, "R8");
        one_cycle(IP_C, 0, IP_C, 1, 1, "R8");
        one_cycle(IP_C, 0, 0, 0, 0, "R8");
        // R9: back-to-back mispredictions
        one_cycle(0, 1, IP_D, 1, 1, "R9");
        one_cycle(0, 1, IP_E, 1, 1, "R9");
        one_cycle(IP_D, 0, 0, 0, 0, "R9");
        one_cycle(IP_E, 0, 0, 0, 0, "R9");
        // R2: random mix over a small aliasing set of IPs
        for (int n = 0; n < 3000; n++) begin
            logic [IP_W-1:0] lip, rip;
            lip = $urandom() & 32'hF000_01C7;
            rip = ($urandom() % 2 == 0) ? lip : ($urandom() & 32'hF000_01C7);
            one_cycle(lip, ($urandom() % 4) != 0, rip, ($urandom() % 2) == 0,
                      ($urandom() % 3) == 0, "R2");
        end
        one_cycle(0, 0, 0, 0, 0, "R6");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule